// File: doc/BRIEF.md
# Core Idle State Controller

This block follows the idle power state of a single processor core. The core asks to go idle by presenting a request with a target depth: halt, monitor-wait C1, C2, C3 or C4. The controller moves the core into that state and services snoops in the shallow states. In the deep states it first runs a cache-flush handshake and then gates the core clock. It brings the core back to active when a wake event arrives. A stop-clock line from the system can park a halted core in a stop-grant condition, and entering C2 while stop-clock is high is acknowledged with a one-cycle pulse.

The controller reports its state as a 3-bit code. It raises a deep-idle flag while the core sits in C4. A small combiner turns that flag, the flag of the peer core and a software enable into a package deeper-sleep request. Reset is synchronous and active-high.

Top module: `core_idle_ctl`

## Requirements
- R1: During and after reset the state code is 0 (active). In that state clk_en is 1 and flush_req, sg_ack, stop_granted, deep_idle and pkg_sleep_req are all 0. Reset overrides every other input from any state.
- R2: In active, a request with req_level 1 (halt), 2 (C1) or 3 (C2) moves the state code to that same value on the next clock edge. Level codes 0, 6 and 7 are ignored.
- R3: A wake event in active keeps the core in active, even when a request arrives in the same cycle. A request made while the state is not active has no effect.
- R4: From halt (1), C1 (2) or C2 (3), a snoop moves the state to snoop-service (6). A later snoop_done returns the state to the idle state it came from.
- R5: In halt, stop_clk sets stop_granted and gives a one-cycle sg_ack pulse, while the state stays 1. While stop_granted is high, wakes and snoops are held off. Dropping stop_clk clears stop_granted and leaves the state in halt.
- R6: In halt, C1 or C2, a system-management interrupt with no other wake goes to halt if smi_ret_halt is 1 and to active if it is 0. In C3 or C4 it always goes to active.
- R7: A monitor trigger has no effect in halt. It returns C1, C2, C3 and C4 to active.
- R8: A C2 entry produces an sg_ack pulse in the entry cycle only if stop_clk is high together with the request. Otherwise no pulse is produced.
- R9: A request for C3 (4) or C4 (5) first enters flush-wait (7) with flush_req high and clk_en still 1. The state moves to the requested deep state, with flush_req 0 and clk_en 0, only after flush_done.
- R10: In C3 or C4 a snoop leaves the state unchanged. Init, either local interrupt line, a bus interrupt message, a system-management interrupt or a monitor trigger returns the state to active with clk_en 1.
- R11: deep_idle is 1 exactly while the state is C4. pkg_sleep_req is 1 only when deep_idle, peer_deep and deep_sleep_en are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Idle-entry request strobe |
| req_level | input | 3 | Requested depth: 1 halt, 2 C1, 3 C2, 4 C3, 5 C4 |
| stop_clk | input | 1 | System stop-clock request |
| snoop | input | 1 | Snoop arrives for this core |
| snoop_done | input | 1 | Snoop service finished |
| flush_done | input | 1 | Cache flush completed |
| wake_mon | input | 1 | Monitor trigger event |
| wake_smi | input | 1 | System-management interrupt |
| smi_ret_halt | input | 1 | Handler return target: 1 halt, 0 active |
| wake_init | input | 1 | Init event |
| wake_lint | input | LINT_W (2) | Local interrupt lines |
| wake_busint | input | 1 | Bus interrupt message |
| peer_deep | input | 1 | Peer core reports C4 |
| deep_sleep_en | input | 1 | Software enable for package deeper sleep |
| state | output | 3 | Current state code (6 snoop-service, 7 flush-wait) |
| flush_req | output | 1 | Cache-flush request |
| clk_en | output | 1 | Core clock enable |
| sg_ack | output | 1 | Stop-grant acknowledge pulse |
| stop_granted | output | 1 | Halted core is parked in stop-grant |
| deep_idle | output | 1 | Core is in C4 |
| pkg_sleep_req | output | 1 | Package deeper-sleep request |

## Verification
The bench holds flush_done low for several cycles. A design that gated the clock early would show clk_en low while the state is still 7. It sends a snoop into C3 and expects the state to stay put, so a design that woke on snoops would leave the deep state. A request in the same cycle as a wake must leave the core in active, and a request in halt must not reach flush-wait. The bench also covers the two return targets of the system-management interrupt and the monitor trigger in halt against C1. It checks the C2 acknowledge with and without stop-clock, and that snoop_done returns C1 to C1 rather than to halt.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_HALT   = 3'd1,
        ST_C1     = 3'd2,
        ST_C2     = 3'd3,
        ST_C3     = 3'd4,
        ST_C4     = 3'd5,
        ST_SNOOP  = 3'd6,
        ST_FLUSH  = 3'd7
    } idle_state_t;

    typedef struct packed {
        logic hard;
        logic smi;
        logic mon;
    } wake_vec_t;

    function automatic logic is_deep(idle_state_t s);
        return (s == ST_C3) || (s == ST_C4);
    endfunction

    function automatic logic is_shallow(idle_state_t s);
        return (s == ST_HALT) || (s == ST_C1) || (s == ST_C2);
    endfunction

endpackage

// File: rtl/core_wake_merge.sv
module core_wake_merge
    import core_idle_pkg::*;
#(
    parameter int LINT_W = 2
) (
    input  logic              init_i,
    input  logic [LINT_W-1:0] lint_i,
    input  logic              busint_i,
    input  logic              smi_i,
    input  logic              mon_i,
    output wake_vec_t         wake_o
);
    logic [LINT_W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < LINT_W; g++) begin : g_lint
        assign chain[g+1] = chain[g] | lint_i[g];
    end

    always_comb begin
        wake_o.hard = init_i | busint_i | chain[LINT_W];
        wake_o.smi  = smi_i;
        wake_o.mon  = mon_i;
    end
endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
    import core_idle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_level,
    input  logic        stop_clk,
    input  logic        snoop,
    input  logic        snoop_done,
    input  logic        flush_done,
    input  logic        smi_ret_halt,
    input  wake_vec_t   wake,
    output idle_state_t st_o,
    output logic        sg_ack_o,
    output logic        sg_hold_o
);
    idle_state_t st, st_n, ret, ret_n;
    logic        sg, sg_n, ack, ack_n;
    idle_state_t lvl;
    logic        any_wake;

    assign lvl      = idle_state_t'(req_level);
    assign any_wake = wake.hard | wake.smi | wake.mon;

    always_comb begin
        st_n  = st;
        ret_n = ret;
        sg_n  = sg;
        ack_n = 1'b0;
        case (st)
            ST_ACTIVE: begin
                if (!any_wake && req_valid) begin
                    case (lvl)
                        ST_HALT, ST_C1, ST_C2: begin
                            st_n  = lvl;
                            ack_n = (lvl == ST_C2) && stop_clk;
                        end
                        ST_C3, ST_C4: begin
                            st_n  = ST_FLUSH;
                            ret_n = lvl;
                        end
                        default: ;
                    endcase
                end
            end
            ST_HALT, ST_C1, ST_C2: begin
                if (sg) begin
                    if (!stop_clk) sg_n = 1'b0;
                end else if (wake.hard) begin
                    st_n = ST_ACTIVE;
                end else if (wake.smi) begin
                    st_n = smi_ret_halt ? ST_HALT : ST_ACTIVE;
                end else if (wake.mon && st != ST_HALT) begin
                    st_n = ST_ACTIVE;
                end else if (st == ST_HALT && stop_clk) begin
                    sg_n  = 1'b1;
                    ack_n = 1'b1;
                end else if (snoop) begin
                    st_n  = ST_SNOOP;
                    ret_n = st;
                end
            end
            ST_SNOOP: if (snoop_done) st_n = ret;
            ST_FLUSH: if (flush_done) st_n = ret;
            ST_C3, ST_C4: if (any_wake) st_n = ST_ACTIVE;
            default: st_n = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_ACTIVE;
            ret <= ST_ACTIVE;
            sg  <= 1'b0;
            ack <= 1'b0;
        end else begin
            st  <= st_n;
            ret <= ret_n;
            sg  <= sg_n;
            ack <= ack_n;
        end
    end

    assign st_o      = st;
    assign sg_ack_o  = ack;
    assign sg_hold_o = sg;

    // R9: a deep state is reached only through flush-wait with flush_done
    a_r9_flush_first: assert property (@(posedge clk) disable iff (rst)
        (is_deep(st) && $past(st) != st) |-> ($past(st) == ST_FLUSH && $past(flush_done)));

    // R10: snoops do not disturb a deep state
    a_r10_deep_snoop: assert property (@(posedge clk) disable iff (rst)
        (is_deep(st) && snoop && !any_wake) |=> (st == $past(st)));

    // R3: wake wins over an entry request in active
    a_r3_wake_wins: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE && any_wake) |=> (st == ST_ACTIVE));

    // R3: entry request ignored while halted and otherwise quiet
    a_r3_entry_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT && !sg && req_valid && !any_wake && !snoop && !stop_clk) |=> (st == ST_HALT));

    // R5: acknowledge is a single-cycle pulse
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        sg_ack_o |=> !sg_ack_o);

    // R5: stop-grant only ever exists in halt
    a_r5_sg_in_halt: assert property (@(posedge clk) disable iff (rst)
        sg_hold_o |-> (st == ST_HALT));
endmodule

// File: rtl/core_pkg_combine.sv
module core_pkg_combine (
    input  logic own_deep,
    input  logic peer_deep,
    input  logic enable,
    output logic sleep_req
);
    assign sleep_req = own_deep & peer_deep & enable;
endmodule

// File: rtl/core_idle_ctl.sv
module core_idle_ctl
    import core_idle_pkg::*;
#(
    parameter int LINT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_level,
    input  logic              stop_clk,
    input  logic              snoop,
    input  logic              snoop_done,
    input  logic              flush_done,
    input  logic              wake_mon,
    input  logic              wake_smi,
    input  logic              smi_ret_halt,
    input  logic              wake_init,
    input  logic [LINT_W-1:0] wake_lint,
    input  logic              wake_busint,
    input  logic              peer_deep,
    input  logic              deep_sleep_en,
    output logic [2:0]        state,
    output logic              flush_req,
    output logic              clk_en,
    output logic              sg_ack,
    output logic              stop_granted,
    output logic              deep_idle,
    output logic              pkg_sleep_req
);
    wake_vec_t   wv;
    idle_state_t cur;

    core_wake_merge #(.LINT_W(LINT_W)) u_wake (
        .init_i(wake_init), .lint_i(wake_lint), .busint_i(wake_busint),
        .smi_i(wake_smi), .mon_i(wake_mon), .wake_o(wv)
    );

    core_idle_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .stop_clk(stop_clk), .snoop(snoop), .snoop_done(snoop_done),
        .flush_done(flush_done), .smi_ret_halt(smi_ret_halt), .wake(wv),
        .st_o(cur), .sg_ack_o(sg_ack), .sg_hold_o(stop_granted)
    );

    assign state     = cur;
    assign flush_req = (cur == ST_FLUSH);
    assign clk_en    = !is_deep(cur);
    assign deep_idle = (cur == ST_C4);

    core_pkg_combine u_comb (
        .own_deep(deep_idle), .peer_deep(peer_deep),
        .enable(deep_sleep_en), .sleep_req(pkg_sleep_req)
    );

    // R11: package request never without this core in C4
    a_r11_pkg_needs_c4: assert property (@(posedge clk) disable iff (rst)
        pkg_sleep_req |-> (state == 3'd5));
endmodule

// File: tb/test_core_idle_ctl.sv
module test_core_idle_ctl;
    logic clk = 1'b0;
    logic rst;
    logic req_valid, stop_clk, snoop, snoop_done, flush_done;
    logic wake_mon, wake_smi, smi_ret_halt, wake_init, wake_busint;
    logic peer_deep, deep_sleep_en;
    logic [1:0] wake_lint;
    logic [2:0] req_level;
    logic [2:0] state;
    logic flush_req, clk_en, sg_ack, stop_granted, deep_idle, pkg_sleep_req;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    core_idle_ctl i_core_idle_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .stop_clk(stop_clk), .snoop(snoop), .snoop_done(snoop_done),
        .flush_done(flush_done), .wake_mon(wake_mon), .wake_smi(wake_smi),
        .smi_ret_halt(smi_ret_halt), .wake_init(wake_init), .wake_lint(wake_lint),
        .wake_busint(wake_busint), .peer_deep(peer_deep), .deep_sleep_en(deep_sleep_en),
        .state(state), .flush_req(flush_req), .clk_en(clk_en), .sg_ack(sg_ack),
        .stop_granted(stop_granted), .deep_idle(deep_idle), .pkg_sleep_req(pkg_sleep_req)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_valid = 0; req_level = 0; stop_clk = 0; snoop = 0; snoop_done = 0;
        flush_done = 0; wake_mon = 0; wake_smi = 0; smi_ret_halt = 0;
        wake_init = 0; wake_lint = 0; wake_busint = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic go_active();
        quiet();
        wake_init = 1;
        step();
        quiet();
    endtask

    task automatic enter(int lvl);
        req_valid = 1; req_level = 3'(lvl);
        step();
        quiet();
    endtask

    task automatic enter_deep(int lvl);
        enter(lvl);
        flush_done = 1;
        step();
        quiet();
    endtask

    task automatic t_reset();
        rst = 1; quiet(); peer_deep = 0; deep_sleep_en = 0;
        step(); step();
        chk("R1 state", state, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 outputs", {flush_req, sg_ack, stop_granted, deep_idle, pkg_sleep_req}, 0);
        rst = 0;
        step();
        chk("R1 after release", state, 0);
    endtask

    task automatic t_entry();
        enter(1); chk("R2 halt", state, 1); go_active();
        enter(2); chk("R2 c1", state, 2); go_active();
        enter(3); chk("R2 c2", state, 3); go_active();
        enter(6); chk("R2 bad code ignored", state, 0);
        enter(0); chk("R2 zero code ignored", state, 0);
    endtask

    task automatic t_wake_wins();
        req_valid = 1; req_level = 3'd1; wake_lint = 2'b01;
        step(); quiet();
        chk("R3 wake wins", state, 0);
        enter(1);
        enter(5);
        chk("R3 entry ignored in halt", state, 1);
        chk("R3 no flush", flush_req, 0);
        go_active();
    endtask

    task automatic t_snoop();
        enter(1);
        snoop = 1; step(); quiet();
        chk("R4 halt to snoop", state, 6);
        step(); chk("R4 waits done", state, 6);
        snoop_done = 1; step(); quiet();
        chk("R4 back to halt", state, 1);
        go_active();
        enter(2);
        snoop = 1; step(); quiet();
        snoop_done = 1; step(); quiet();
        chk("R4 back to c1", state, 2);
        go_active();
    endtask

    task automatic t_stop_grant();
        enter(1);
        stop_clk = 1; step();
        chk("R5 granted", stop_granted, 1);
        chk("R5 ack pulse", sg_ack, 1);
        chk("R5 state halt", state, 1);
        wake_init = 1; snoop = 1; step();
        wake_init = 0; snoop = 0;
        chk("R5 ack cleared", sg_ack, 0);
        chk("R5 wake held off", state, 1);
        stop_clk = 0; step();
        chk("R5 released", stop_granted, 0);
        chk("R5 returns halt", state, 1);
        go_active();
    endtask

    task automatic t_smi();
        enter(1);
        wake_smi = 1; smi_ret_halt = 1; step(); quiet();
        chk("R6 smi to halt", state, 1);
        wake_smi = 1; smi_ret_halt = 0; step(); quiet();
        chk("R6 smi to active", state, 0);
        enter_deep(4);
        wake_smi = 1; smi_ret_halt = 1; step(); quiet();
        chk("R6 smi from c3", state, 0);
    endtask

    task automatic t_monitor();
        enter(1);
        wake_mon = 1; step(); quiet();
        chk("R7 halt ignores monitor", state, 1);
        go_active();
        enter(2);
        wake_mon = 1; step(); quiet();
        chk("R7 c1 wakes", state, 0);
    endtask

    task automatic t_c2_ack();
        req_valid = 1; req_level = 3'd3; stop_clk = 1;
        step(); quiet();
        chk("R8 c2 with stop", state, 3);
        chk("R8 ack", sg_ack, 1);
        step(); chk("R8 ack once", sg_ack, 0);
        go_active();
        enter(3);
        chk("R8 no ack without stop", sg_ack, 0);
        go_active();
    endtask

    task automatic t_flush();
        enter(5);
        chk("R9 flush state", state, 7);
        chk("R9 flush_req", flush_req, 1);
        chk("R9 clock runs", clk_en, 1);
        step(); step(); step();
        chk("R9 still waiting", state, 7);
        chk("R9 clock still runs", clk_en, 1);
        flush_done = 1; step(); quiet();
        chk("R9 in c4", state, 5);
        chk("R9 clock off", clk_en, 0);
        chk("R9 flush dropped", flush_req, 0);
        go_active();
    endtask

    task automatic t_deep_wake();
        enter_deep(4);
        chk("R10 in c3", state, 4);
        snoop = 1; step(); step(); quiet();
        chk("R10 snoop ignored", state, 4);
        chk("R10 clock still off", clk_en, 0);
        wake_lint = 2'b10; step(); quiet();
        chk("R10 lint1 wakes", state, 0);
        chk("R10 clock on", clk_en, 1);
        enter_deep(5); wake_lint = 2'b01; step(); quiet();
        chk("R10 lint0 wakes", state, 0);
        enter_deep(5); wake_busint = 1; step(); quiet();
        chk("R10 busint wakes", state, 0);
        enter_deep(4); wake_mon = 1; step(); quiet();
        chk("R10 monitor wakes", state, 0);
        enter_deep(4); wake_init = 1; step(); quiet();
        chk("R10 init wakes", state, 0);
    endtask

    task automatic t_pkg();
        enter_deep(4);
        chk("R11 c3 not deep", deep_idle, 0);
        go_active();
        enter_deep(5);
        chk("R11 c4 deep", deep_idle, 1);
        peer_deep = 1; deep_sleep_en = 0; #1;
        chk("R11 no enable", pkg_sleep_req, 0);
        deep_sleep_en = 1; #1;
        chk("R11 request", pkg_sleep_req, 1);
        peer_deep = 0; #1;
        chk("R11 peer awake", pkg_sleep_req, 0);
        peer_deep = 1;
        rst = 1; step();
        chk("R1 reset from c4", state, 0);
        chk("R1 pkg dropped", pkg_sleep_req, 0);
        rst = 0; peer_deep = 0; deep_sleep_en = 0;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #400000;
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #1;
        t_reset();
        t_entry();
        t_wake_wins();
        t_snoop();
        t_stop_grant();
        t_smi();
        t_monitor();
        t_c2_ack();
        t_flush();
        t_deep_wake();
        t_pkg();
        finish_run();
    end
endmodule